// File: doc/BRIEF.md
# ADC Start-of-Conversion Controller

This block decides when a successive-approximation converter begins a conversion, and it times that conversion. A conversion can be started in two ways. Software can pulse a start request. Hardware can start one through a rising edge on one of several trigger inputs, chosen by a 3-bit select field. Select code 0 chooses the block's own completion flag as the source, which gives back-to-back free-running conversions. A 7-bit prescaler divides the system clock down to a converter tick. Each conversion lasts a fixed number of those ticks, and a counter models the analog part of the conversion.

A busy output stays high for the whole of every conversion, however that conversion was started. A sticky completion flag is raised at the end of every conversion and is cleared by a write-one pulse. While the flag is set it blocks ordinary hardware triggers. In free-running mode it does not block anything. Trigger edges that arrive during a conversion are dropped and are not stored.

Top module: `adc_trig_ctrl`

## Requirements
- R1: The tick output pulses once every 2^k system clocks while `adc_en` is high, where k = max(`pre_sel`, 1), so codes 0 and 1 both divide by 2 and code 7 divides by 128. While `adc_en` is low the tick never pulses and the divider count is held at zero.
- R2: A conversion covers 13 ticks seen while `busy` is high. `conv_done` pulses in the cycle of the 13th tick, and `busy` is low on the following clock unless a free-running restart applies.
- R3: A `sw_start` pulse while enabled and idle sets `busy` on the next clock, whatever the value of `auto_en` or the select field. A `sw_start` pulse while busy has no effect, and no second conversion follows.
- R4: With `auto_en` high and `trig_sel` = n in 1..7, a rising edge on `trig_src[n-1]` sets `busy` on the next clock if the block is idle and the flag is clear.
- R5: A rising trigger edge during a conversion neither alters that conversion nor starts another one after it.
- R6: `done_flag` is set on the clock after `conv_done` and stays set until a `flag_clr` pulse. If setting and clearing fall in the same cycle, setting wins.
- R7: While `done_flag` is set and the select field is non-zero, a trigger edge does not start a conversion.
- R8: With `auto_en` high and `trig_sel` = 0, each `conv_done` is followed at once by a new conversion, whether or not the flag is set. The first conversion of that mode needs `sw_start`.
- R9: A change of `trig_sel` to a source that is already high does not count as an edge.
- R10: Dropping `adc_en` aborts a running conversion (`busy` low on the next clock, no `conv_done`) and blocks all starts.
- R11: With `auto_en` low, edges on the trigger inputs start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adc_en | input | 1 | Converter enable; when low, holds the prescaler in reset and aborts any conversion |
| auto_en | input | 1 | Enables hardware triggering |
| trig_sel | input | 3 | Trigger select: 0 = completion flag (free running), n = trig_src[n-1] |
| trig_src | input | 7 | Hardware trigger inputs |
| sw_start | input | 1 | Software start pulse |
| flag_clr | input | 1 | Write-one-to-clear pulse for the completion flag |
| pre_sel | input | 3 | Prescale select |
| adc_tick | output | 1 | Converter clock enable from the prescaler |
| busy | output | 1 | Start/busy status, high during every conversion |
| conv_done | output | 1 | One-cycle end-of-conversion pulse |
| done_flag | output | 1 | Sticky completion flag |

## Verification
The assertions assume that `sw_start` and `flag_clr` are single-cycle pulses and that all inputs are synchronous to `clk`. The stimulus changes every input on the falling edge and raises each request for exactly one cycle. The assertions also assume that `adc_en` and `auto_en` stay constant across a clock edge at which they are evaluated together with `conv_done`. The bench changes these mode inputs only while the block is idle, or between two observed completions. Trigger inputs are treated as already synchronised, so the stimulus holds each trigger level for at least one full clock.

// File: rtl/adc_trig_pkg.sv
`timescale 1ns/1ps
package adc_trig_pkg;
  localparam int unsigned PRE_W      = 7;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned CONV_TICKS = 13;

  // Mask of low divider bits; tick fires when they are all ones.
  function automatic logic [PRE_W-1:0] div_mask(input logic [SEL_W-1:0] code);
    int unsigned k;
    k = (code < 1) ? 1 : int'(code);
    if (k > PRE_W) k = PRE_W;
    return PRE_W'((1 << k) - 1);
  endfunction
endpackage

// File: rtl/adc_prescaler.sv
`timescale 1ns/1ps
module adc_prescaler
  import adc_trig_pkg::*;
#(
  parameter int unsigned W  = PRE_W,
  parameter int unsigned SW = SEL_W
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [SW-1:0] sel,
  output logic          tick
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] mask;

  always_comb begin
    mask = W'(div_mask(SEL_W'(sel)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (!en) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end

  assign tick = en && ((cnt_q & mask) == mask);
endmodule

// File: rtl/adc_trig_detect.sv
`timescale 1ns/1ps
module adc_trig_detect #(
  parameter int unsigned SW   = 3,
  localparam int unsigned NSRC = (1 << SW) - 1
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW-1:0]   sel,
  input  logic [NSRC-1:0] src,
  input  logic            flag,
  output logic            rise,
  output logic            free_run
);
  logic [NSRC:0] pool;
  logic          cur;
  logic          prev_q;
  logic [SW-1:0] sel_q;

  assign pool     = {src, flag};
  assign cur      = pool[sel];
  assign free_run = (sel == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      prev_q <= cur;
      sel_q  <= sel;
    end
  end

  // No edge on the cycle the select changes.
  assign rise = cur && !prev_q && (sel == sel_q);
endmodule

// File: rtl/adc_conv_seq.sv
`timescale 1ns/1ps
module adc_conv_seq #(
  parameter int unsigned TICKS = 13,
  localparam int unsigned CW   = $clog2(TICKS)
)(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic start,
  input  logic restart,
  input  logic clr,
  output logic busy,
  output logic done,
  output logic flag
);
  logic [CW-1:0] tcnt_q;
  logic          busy_q;
  logic          flag_q;

  assign done = busy_q && tick && (tcnt_q == CW'(TICKS - 1));
  assign busy = busy_q;
  assign flag = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tcnt_q <= '0;
    end else if (!en) begin
      busy_q <= 1'b0;
      tcnt_q <= '0;
    end else if (done) begin
      busy_q <= restart;
      tcnt_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      tcnt_q <= '0;
    end else if (busy_q && tick) begin
      tcnt_q <= tcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (done) flag_q <= 1'b1;
    else if (clr)  flag_q <= 1'b0;
  end
endmodule

// File: rtl/adc_trig_ctrl.sv
`timescale 1ns/1ps
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int unsigned PW    = PRE_W,
  parameter int unsigned SW    = SEL_W,
  parameter int unsigned TICKS = CONV_TICKS,
  localparam int unsigned NSRC = (1 << SW) - 1
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adc_en,
  input  logic            auto_en,
  input  logic [SW-1:0]   trig_sel,
  input  logic [NSRC-1:0] trig_src,
  input  logic            sw_start,
  input  logic            flag_clr,
  input  logic [2:0]      pre_sel,
  output logic            adc_tick,
  output logic            busy,
  output logic            conv_done,
  output logic            done_flag
);
  // Named internal events, brought out for the checker.
  logic trig_rise;
  logic free_run;
  logic hw_start;
  logic sw_go;
  logic fr_restart;
  logic start_any;

  adc_prescaler #(.W(PW), .SW(3)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(adc_en), .sel(pre_sel), .tick(adc_tick)
  );

  adc_trig_detect #(.SW(SW)) u_det (
    .clk(clk), .rst_n(rst_n), .sel(trig_sel), .src(trig_src),
    .flag(done_flag), .rise(trig_rise), .free_run(free_run)
  );

  assign hw_start   = adc_en && auto_en && !free_run && trig_rise && !busy && !done_flag;
  assign sw_go      = adc_en && sw_start && !busy;
  assign fr_restart = adc_en && auto_en && free_run;
  assign start_any  = hw_start || sw_go;

  adc_conv_seq #(.TICKS(TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(adc_en), .tick(adc_tick),
    .start(start_any), .restart(fr_restart), .clr(flag_clr),
    .busy(busy), .done(conv_done), .flag(done_flag)
  );
endmodule

// File: rtl/adc_trig_ctrl_chk.sv
`timescale 1ns/1ps
module adc_trig_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic adc_en,
  input logic auto_en,
  input logic sw_start,
  input logic adc_tick,
  input logic busy,
  input logic conv_done,
  input logic done_flag,
  input logic free_run,
  input logic start_any
);
  p_tick_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    adc_tick |-> adc_en);

  p_done_inside_conv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> busy);

  p_end_without_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !(auto_en && free_run)) |=> !busy);

  p_start_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_any && adc_en) |=> busy);

  p_conv_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && adc_en && !conv_done) |=> busy);

  p_done_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> done_flag);

  p_flag_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && done_flag && !free_run && !sw_start) |=> !busy);

  p_free_run_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && adc_en && auto_en && free_run) |=> busy);

  p_disable_aborts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_en |=> !busy);
endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .adc_en(adc_en), .auto_en(auto_en),
  .sw_start(sw_start), .adc_tick(adc_tick), .busy(busy),
  .conv_done(conv_done), .done_flag(done_flag), .free_run(free_run),
  .start_any(start_any)
);

// File: tb/test_adc_trig_ctrl.sv
`timescale 1ns/1ps
module test_adc_trig_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       adc_en = 1'b0, auto_en = 1'b0, sw_start = 1'b0, flag_clr = 1'b0;
  logic [2:0] trig_sel = 3'd1, pre_sel = 3'd0;
  logic [6:0] trig_src = '0;
  logic       adc_tick, busy, conv_done, done_flag;

  int n_chk = 0, n_bad = 0;
  int exp_q[$];
  int tick_seen = 0;

  always #10 clk = ~clk; // 50 MHz

  adc_trig_ctrl i_adc_trig_ctrl (
    .clk(clk), .rst_n(rst_n), .adc_en(adc_en), .auto_en(auto_en),
    .trig_sel(trig_sel), .trig_src(trig_src), .sw_start(sw_start),
    .flag_clr(flag_clr), .pre_sel(pre_sel), .adc_tick(adc_tick),
    .busy(busy), .conv_done(conv_done), .done_flag(done_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: count ticks inside each conversion, compare on completion.
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && adc_tick) tick_seen++;
      if (conv_done) begin
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected completion", 1, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check(tick_seen == e, "R2 ticks per conversion", tick_seen, e);
        end
        tick_seen = 0;
      end
      if (!busy) tick_seen = 0;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_sw();
    sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t;
    t = 0;
    while (!conv_done && t < 3000) begin @(negedge clk); t++; end
    check(conv_done, req, 0, 1);
  endtask

  task automatic measure_period(input logic [2:0] s);
    int n, exp;
    pre_sel = s;
    cyc(2);
    while (!adc_tick) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!adc_tick && n < 300);
    exp = (s < 3'd1) ? 2 : (1 << s);
    check(n == exp, "R1 tick period", n, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int tc;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    check(!busy, "R3 reset busy", busy, 0);
    check(!done_flag, "R6 reset flag", done_flag, 0);
    // R1: no tick while disabled
    tc = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); tc += adc_tick; end
    check(tc == 0, "R1 no tick when disabled", tc, 0);
    adc_en = 1'b1;
    for (int s = 0; s < 8; s++) measure_period(3'(s));
    pre_sel = 3'd0;
    cyc(2);

    // R3: software start, busy throughout, sw_start while busy ignored
    exp_q.push_back(13);
    pulse_sw();
    check(busy, "R3 busy after sw start", busy, 1);
    cyc(5);
    pulse_sw();
    check(busy, "R3 busy mid conversion", busy, 1);
    wait_done("R2 completion");
    @(negedge clk);
    check(!busy, "R2 busy clears after done", busy, 1'b0);
    check(done_flag, "R6 flag set", done_flag, 1);
    cyc(40);
    check(!busy, "R3 no queued second conversion", busy, 0);
    pulse_clr();
    check(!done_flag, "R6 flag cleared", done_flag, 0);

    // R11: trigger edge with auto_en low
    trig_sel = 3'd3;
    cyc(2);
    trig_src[2] = 1'b1; cyc(3);
    check(!busy, "R11 edge ignored without auto", busy, 0);
    trig_src[2] = 1'b0; cyc(2);

    // R4: hardware edge starts conversion
    auto_en = 1'b1;
    exp_q.push_back(13);
    trig_src[2] = 1'b1; @(negedge clk);
    check(busy, "R4 edge starts conversion", busy, 1);
    // R5: edge during conversion dropped
    trig_src[2] = 1'b0; cyc(2);
    trig_src[2] = 1'b1; cyc(2);
    check(busy, "R5 conversion continues", busy, 1);
    wait_done("R4 completion");
    cyc(40);
    check(!busy, "R5 edge not queued", busy, 0);
    // R7: flag set blocks edge
    trig_src[2] = 1'b0; cyc(2);
    trig_src[2] = 1'b1; cyc(3);
    check(!busy, "R7 flag blocks trigger", busy, 0);
    // R6: set beats clear in same cycle is covered by the assertion; here, clear then trigger
    pulse_clr();
    trig_src[2] = 1'b0; cyc(2);
    exp_q.push_back(13);
    trig_src[2] = 1'b1; @(negedge clk);
    check(busy, "R7 trigger after flag clear", busy, 1);
    wait_done("R4 second completion");
    cyc(2);
    pulse_clr();

    // R9: select switch onto high source gives no edge
    trig_src = 7'b0000001;
    trig_sel = 3'd5;
    cyc(3);
    trig_sel = 3'd1;
    cyc(4);
    check(!busy, "R9 no spurious edge on select change", busy, 0);
    trig_src = '0;

    // R8: free running
    trig_sel = 3'd0;
    cyc(40);
    check(!busy, "R8 free run needs software start", busy, 0);
    repeat (4) exp_q.push_back(13);
    pulse_sw();
    for (int k = 0; k < 3; k++) begin
      wait_done("R8 chained completion");
      @(negedge clk);
      check(busy, "R8 restart after done", busy, 1);
    end
    check(done_flag, "R8 flag left set", done_flag, 1);
    auto_en = 1'b0;
    wait_done("R8 final completion");
    @(negedge clk);
    check(!busy, "R8 stops without auto", busy, 1'b0);
    pulse_clr();
    trig_sel = 3'd1;

    // R10: disable aborts
    pulse_sw();
    cyc(6);
    adc_en = 1'b0;
    @(negedge clk);
    check(!busy, "R10 abort on disable", busy, 0);
    check(!adc_tick, "R10 no tick when disabled", adc_tick, 0);
    pulse_sw();
    cyc(3);
    check(!busy, "R10 no start when disabled", busy, 0);
    adc_en = 1'b1;
    cyc(60);
    check(exp_q.size() == 0, "R2 all completions seen", exp_q.size(), 0);
    check(!done_flag, "R10 no completion after abort", done_flag, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule